// File: doc/BRIEF.md
# Framebuffer Address Mapper

This block sits between a 32-bit CPU address bus and the 21-bit address port of a video RAM that holds one 640 x 480 framebuffer. It offers the CPU three ways to reach the same pixels. In the coordinate window the low half of the CPU address carries X and the high half carries Y, so a plotting routine can write a pixel without multiplying. In the linear window the low 21 address bits go straight to the video RAM. In the scanline window one row is chosen by a writable row register, and a short offset selects the pixel in that row.

Address decoding and address forming are combinational. Only the row register holds state. It updates on the clock edge and can be read back at its own CPU address. The video RAM chip select is asserted only for a valid window hit. The CPU write strobe goes to the video RAM unchanged.

Top module: `fb_addr_map`

## Requirements
- R1: A selected access with cpu_addr_i[31:28] = 4'h8 asserts vram_cs_o. It drives vram_addr_o = {2'b00, cpu_addr_i[24:16], cpu_addr_i[9:0]}, so each row is 1024 words apart. For example, 0x8001_0000 maps to 0x400 and 0x81DF_027F maps to 0x77E7F.
- R2: The coordinate window does no bounds check. An X above 639 or a Y above 479 still gives the formed address with vram_cs_o high.
- R3: A selected access in 0x9000_0000 to 0x901F_FFFF asserts vram_cs_o with vram_addr_o = cpu_addr_i[20:0].
- R4: A selected access in 0xB000_0000 to 0xB000_03FF with offset cpu_addr_i[9:0] below 640 asserts vram_cs_o with vram_addr_o = {2'b00, row, offset}, where row is the row register.
- R5: A scanline-window access with offset 640 or more keeps vram_cs_o low.
- R6: vram_cs_o is low when cpu_sel_i is low, and for any address outside the three windows.
- R7: The row register sits at CPU address 0xA000_0000. On a clock edge with cpu_sel_i and cpu_we_i high at that address, it takes cpu_wdata_i[8:0]. While that address is selected, reg_hit_o is high and reg_rdata_o shows the register zero-extended. Otherwise reg_rdata_o is 0.
- R8: After reset, the row register is 0.
- R9: vram_we_o always equals cpu_we_i.
- R10: An access to the register address never asserts vram_cs_o. A read there (cpu_we_i low) leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 32 | CPU byte/word address |
| cpu_sel_i | input | 1 | CPU access valid |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 16 | CPU write data (register writes) |
| vram_addr_o | output | 21 | Video RAM address |
| vram_cs_o | output | 1 | Video RAM chip select |
| vram_we_o | output | 1 | Video RAM write enable |
| reg_hit_o | output | 1 | Row register addressed |
| reg_rdata_o | output | 16 | Row register read-back |

## Verification
The bench builds the block with its default parameters: a 10-bit X field, a 9-bit Y field, a 21-bit video RAM address and a 640-pixel line limit. With these values the full coordinate range can be driven, including X = 1023 and Y = 511 beyond the visible area, together with the exact 639/640 edge of the scanline window. Row register values 0, 479 and 511 are written and read back, so the top row bit and the cut of wider write data are both exercised.

// File: rtl/fb_map_pkg.sv
package fb_map_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_COORD,
    WIN_LIN,
    WIN_LINE,
    WIN_REG
  } win_e;
endpackage

// File: rtl/fb_win_decode.sv
module fb_win_decode
  import fb_map_pkg::*;
#(
  parameter logic [3:0]  COORD_TAG = 4'h8,
  parameter logic [31:0] LIN_BASE  = 32'h9000_0000,
  parameter int          LIN_AW    = 21,
  parameter logic [31:0] LINE_BASE = 32'hB000_0000,
  parameter int          LINE_AW   = 10,
  parameter logic [31:0] REG_ADDR  = 32'hA000_0000
) (
  input  logic [31:0] addr_i,
  output win_e        win_o
);
  always_comb begin
    win_o = WIN_NONE;
    if (addr_i[31:28] == COORD_TAG)
      win_o = WIN_COORD;
    else if (addr_i[31:LIN_AW] == LIN_BASE[31:LIN_AW])
      win_o = WIN_LIN;
    else if (addr_i[31:LINE_AW] == LINE_BASE[31:LINE_AW])
      win_o = WIN_LINE;
    else if (addr_i == REG_ADDR)
      win_o = WIN_REG;
  end
endmodule

// File: rtl/fb_line_reg.sv
module fb_line_reg #(
  parameter int DATA_W = 16,
  parameter int Y_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [Y_W-1:0]    line_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:Y_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   line_o <= '0;
    else if (wr_i) line_o <= wdata_i[Y_W-1:0];
  end
endmodule

// File: rtl/fb_addr_form.sv
module fb_addr_form
  import fb_map_pkg::*;
#(
  parameter int X_W     = 10,
  parameter int Y_W     = 9,
  parameter int VRAM_AW = 21,
  parameter int LINE_W  = 640
) (
  input  win_e               win_i,
  input  logic               sel_i,
  input  logic [VRAM_AW-1:0] low_i,
  input  logic [Y_W-1:0]     y_i,
  input  logic [Y_W-1:0]     line_i,
  output logic [VRAM_AW-1:0] addr_o,
  output logic               cs_o
);
  localparam int BANK_W = VRAM_AW - X_W - Y_W;
  localparam logic [X_W-1:0] LINE_LIM = X_W'(LINE_W);

  logic [X_W-1:0] x;
  logic           in_line;

  assign x       = low_i[X_W-1:0];
  assign in_line = x < LINE_LIM;

  always_comb begin
    addr_o = '0;
    cs_o   = 1'b0;
    unique case (win_i)
      WIN_COORD: begin
        addr_o = {{BANK_W{1'b0}}, y_i, x};
        cs_o   = sel_i;
      end
      WIN_LIN: begin
        addr_o = low_i;
        cs_o   = sel_i;
      end
      WIN_LINE: begin
        addr_o = {{BANK_W{1'b0}}, line_i, x};
        cs_o   = sel_i & in_line; // keep writes off the hidden row tail
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fb_addr_map.sv
module fb_addr_map
  import fb_map_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int X_W     = 10,
  parameter int Y_W     = 9,
  parameter int Y_LSB   = 16,
  parameter int VRAM_AW = 21,
  parameter int LINE_W  = 640
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        cpu_addr_i,
  input  logic               cpu_sel_i,
  input  logic               cpu_we_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic               vram_cs_o,
  output logic               vram_we_o,
  output logic               reg_hit_o,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  win_e           win;
  logic [Y_W-1:0] line_q;

  fb_win_decode #(.LIN_AW(VRAM_AW), .LINE_AW(X_W)) u_dec (
    .addr_i(cpu_addr_i),
    .win_o (win)
  );

  fb_line_reg #(.DATA_W(DATA_W), .Y_W(Y_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cpu_sel_i & cpu_we_i & (win == WIN_REG)),
    .wdata_i(cpu_wdata_i),
    .line_o (line_q)
  );

  fb_addr_form #(.X_W(X_W), .Y_W(Y_W), .VRAM_AW(VRAM_AW), .LINE_W(LINE_W)) u_form (
    .win_i (win),
    .sel_i (cpu_sel_i),
    .low_i (cpu_addr_i[VRAM_AW-1:0]),
    .y_i   (cpu_addr_i[Y_LSB +: Y_W]),
    .line_i(line_q),
    .addr_o(vram_addr_o),
    .cs_o  (vram_cs_o)
  );

  assign vram_we_o   = cpu_we_i;
  assign reg_hit_o   = cpu_sel_i & (win == WIN_REG);
  assign reg_rdata_o = reg_hit_o ? DATA_W'(line_q) : '0;
endmodule

// File: rtl/fb_addr_map_chk.sv
module fb_addr_map_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cpu_addr_i,
  input logic        cpu_sel_i,
  input logic        cpu_we_i,
  input logic [15:0] cpu_wdata_i,
  input logic [20:0] vram_addr_o,
  input logic        vram_cs_o,
  input logic        vram_we_o,
  input logic        reg_hit_o,
  input logic [15:0] reg_rdata_o
);
  logic reg_acc, reg_wr, line_win;
  assign reg_acc  = cpu_sel_i && cpu_addr_i == 32'hA000_0000;
  assign reg_wr   = reg_acc && cpu_we_i;
  assign line_win = cpu_sel_i && cpu_addr_i[31:10] == 22'h2C0000;

  p_coord_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_sel_i && cpu_addr_i[31:28] == 4'h8) |->
      (vram_cs_o && vram_addr_o == {2'b00, cpu_addr_i[24:16], cpu_addr_i[9:0]}));

  p_lin_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_sel_i && cpu_addr_i[31:21] == 11'h480) |->
      (vram_cs_o && vram_addr_o == cpu_addr_i[20:0]));

  p_line_oob_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_win && cpu_addr_i[9:0] >= 10'd640) |-> !vram_cs_o);

  p_idle_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_sel_i |-> !vram_cs_o);

  p_reg_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr ##1 reg_acc |-> reg_rdata_o == {7'd0, $past(cpu_wdata_i[8:0])});

  p_reg_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_hit_o == reg_acc);

  p_we_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o == cpu_we_i);

  p_reg_no_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_acc |-> !vram_cs_o);

  p_reg_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_acc && !cpu_we_i) ##1 reg_acc |-> $stable(reg_rdata_o));
endmodule

bind fb_addr_map fb_addr_map_chk u_chk (.*);

// File: tb/sim_fb_addr_map.sv
`timescale 1ns/1ps
module sim_fb_addr_map;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cpu_addr_i = '0;
  logic        cpu_sel_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [15:0] cpu_wdata_i = '0;
  logic [20:0] vram_addr_o;
  logic        vram_cs_o, vram_we_o, reg_hit_o;
  logic [15:0] reg_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  fb_addr_map u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let combinational outputs settle
  task automatic put(input logic [31:0] a, input logic s, input logic w, input logic [15:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_sel_i = s; cpu_we_i = w; cpu_wdata_i = d;
    #1;
  endtask

  task automatic wr_line(input logic [15:0] d);
    put(32'hA000_0000, 1'b1, 1'b1, d);
    @(posedge clk_i);
    put(32'h0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic rd_line(input string req, input logic [15:0] exp);
    put(32'hA000_0000, 1'b1, 1'b0, 16'hFFFF);
    chk(req, {31'd0, reg_hit_o}, 32'd1);
    chk(req, {16'd0, reg_rdata_o}, {16'd0, exp});
  endtask

  task automatic t_reset;
    rd_line("R8 reset row", 16'h0);
    chk("R10 reg cs", {31'd0, vram_cs_o}, 32'd0);
  endtask

  task automatic t_coord;
    put(32'h8000_0000, 1'b1, 1'b0, 0); chk("R1 (0,0)", {11'd0, vram_addr_o}, 32'h0);
    chk("R1 cs", {31'd0, vram_cs_o}, 32'd1);
    put(32'h8001_0000, 1'b1, 1'b0, 0); chk("R1 (0,1)", {11'd0, vram_addr_o}, 32'h400);
    put(32'h8014_0014, 1'b1, 1'b1, 0); chk("R1 (20,20)", {11'd0, vram_addr_o}, 32'h5014);
    put(32'h81DF_027F, 1'b1, 1'b0, 0); chk("R1 (639,479)", {11'd0, vram_addr_o}, 32'h77E7F);
    put(32'h8FFE_F801, 1'b1, 1'b0, 0); chk("R1 ignored bits", {11'd0, vram_addr_o}, 32'h7F801);
  endtask

  task automatic t_coord_oob;
    put(32'h81FF_03FF, 1'b1, 1'b0, 0);
    chk("R2 (1023,511) addr", {11'd0, vram_addr_o}, 32'h7FFFF);
    chk("R2 cs", {31'd0, vram_cs_o}, 32'd1);
    put(32'h81E0_0280, 1'b1, 1'b0, 0);
    chk("R2 (640,480) addr", {11'd0, vram_addr_o}, 32'h78280);
    chk("R2 cs edge", {31'd0, vram_cs_o}, 32'd1);
  endtask

  task automatic t_linear;
    put(32'h9000_0000, 1'b1, 1'b0, 0); chk("R3 base", {11'd0, vram_addr_o}, 32'h0);
    chk("R3 cs", {31'd0, vram_cs_o}, 32'd1);
    put(32'h901F_FFFF, 1'b1, 1'b0, 0); chk("R3 top", {11'd0, vram_addr_o}, 32'h1FFFFF);
    put(32'h9012_3456, 1'b1, 1'b0, 0); chk("R3 mid", {11'd0, vram_addr_o}, 32'h123456);
    put(32'h9020_0000, 1'b1, 1'b0, 0); chk("R6 past linear", {31'd0, vram_cs_o}, 32'd0);
  endtask

  task automatic t_line;
    wr_line(16'd479);
    put(32'hB000_0000, 1'b1, 1'b1, 0);
    chk("R4 row479 off0", {11'd0, vram_addr_o}, 32'h77C00);
    chk("R4 cs", {31'd0, vram_cs_o}, 32'd1);
    put(32'hB000_027F, 1'b1, 1'b0, 0);
    chk("R4 off639", {11'd0, vram_addr_o}, 32'h77E7F);
    chk("R4 cs639", {31'd0, vram_cs_o}, 32'd1);
    wr_line(16'd5);
    put(32'hB000_0010, 1'b1, 1'b0, 0);
    chk("R4 row5", {11'd0, vram_addr_o}, 32'h1410);
  endtask

  task automatic t_line_oob;
    put(32'hB000_0280, 1'b1, 1'b1, 0); chk("R5 off640", {31'd0, vram_cs_o}, 32'd0);
    put(32'hB000_03FF, 1'b1, 1'b1, 0); chk("R5 off1023", {31'd0, vram_cs_o}, 32'd0);
  endtask

  task automatic t_nowin;
    put(32'h8000_0010, 1'b0, 1'b1, 0); chk("R6 sel low", {31'd0, vram_cs_o}, 32'd0);
    put(32'h7FFF_FFFF, 1'b1, 1'b0, 0); chk("R6 below", {31'd0, vram_cs_o}, 32'd0);
    put(32'hB000_0400, 1'b1, 1'b0, 0); chk("R6 past line win", {31'd0, vram_cs_o}, 32'd0);
    put(32'hA000_0001, 1'b1, 1'b0, 0); chk("R6 near reg", {31'd0, vram_cs_o}, 32'd0);
    chk("R7 no hit", {31'd0, reg_hit_o}, 32'd0);
    chk("R7 rdata zero", {16'd0, reg_rdata_o}, 32'd0);
  endtask

  task automatic t_reg;
    wr_line(16'hFFFF);
    rd_line("R7 trunc", 16'h01FF);
    wr_line(16'h0123);
    rd_line("R7 write", 16'h0123);
    // read cycle across an edge must not change it
    put(32'hA000_0000, 1'b1, 1'b0, 16'h0055);
    @(posedge clk_i);
    rd_line("R10 read keeps", 16'h0123);
    chk("R10 reg cs", {31'd0, vram_cs_o}, 32'd0);
    // write with sel low ignored
    put(32'hA000_0000, 1'b0, 1'b1, 16'h0077);
    @(posedge clk_i);
    rd_line("R7 sel low ignored", 16'h0123);
    wr_line(16'd0);
    rd_line("R7 back to 0", 16'h0);
  endtask

  task automatic t_we;
    put(32'h9000_0001, 1'b1, 1'b1, 0); chk("R9 we high", {31'd0, vram_we_o}, 32'd1);
    put(32'h7000_0000, 1'b0, 1'b1, 0); chk("R9 we idle", {31'd0, vram_we_o}, 32'd1);
    put(32'h9000_0001, 1'b1, 1'b0, 0); chk("R9 we low", {31'd0, vram_we_o}, 32'd0);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_coord;
    t_coord_oob;
    t_linear;
    t_line;
    t_line_oob;
    t_nowin;
    t_reg;
    t_we;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule